// File: doc/BRIEF.md
# ADC Threshold-Gated Interrupt Sequencer

This block keeps an external analog-to-digital converter busy on a single chosen input channel. It drives the converter with a one-cycle start pulse and waits for a one-cycle done pulse that carries a 10-bit sample. Each sample is written into a result register indexed by the channel that was being converted. The next start is then issued straight away, so conversions run back to back for as long as the run bit stays set.

Each completed conversion can raise a one-cycle interrupt pulse. When comparison is off, every completion raises it. When comparison is on, only completions whose upper eight result bits satisfy a programmable test against an 8-bit threshold raise it. The test is either "at or above" or "strictly below". Conversion continues whether or not the test passes.

Software sets the run bit, compare enable, compare direction, channel and threshold through a simple write-strobe register port. It reads the settings and the per-channel results back through a registered read port.

Top module: `adc_gate_seq_top`

## Requirements
- R1: After reset, conv_start and irq are 0, every result register reads 0, and the control and threshold registers read 0.
- R2: Writing the control register (address 0) with bit 0 (run) set while idle makes conv_start pulse for one cycle. The pulse is high in the second cycle after the write cycle, and conv_chan then equals the channel field, bits 6:4.
- R3: A done pulse during a conversion stores conv_result into the result register of the channel in flight. Result register n is read at address 8+n, right-aligned. reg_rdata shows the register addressed in the previous cycle.
- R4: With run set, a new conv_start pulse is issued in the cycle after each accepted done. It uses the channel field as it stands at that done. conv_chan holds steady while a conversion is in flight.
- R5: With compare enable (control bit 1) clear, irq is a one-cycle pulse in the cycle after every accepted done.
- R6: With compare enable set and direction (control bit 2) clear, irq pulses after a done only if result bits 9:2 are greater than or equal to the threshold (address 1, bits 7:0).
- R7: With compare enable and direction both set, irq pulses after a done only if result bits 9:2 are strictly less than the threshold.
- R8: Clearing run while a conversion is in flight issues no further start. The in-flight done still updates its result register and may still raise irq.
- R9: A done pulse when no conversion is in flight is ignored: no result register changes, and neither irq nor conv_start pulses.
- R10: Threshold, direction and compare-enable writes apply to the next accepted done after the write.
- R11: A result read addressed in the same cycle that a done writes that register returns the value held before the write. The new value is returned one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0 control, 1 threshold, 8..15 results) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 10 | Converter sample, valid with conv_done |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel the converter is told to sample |
| irq | output | 1 | One-cycle conversion-end interrupt |

## Verification
Two things can fall in the same cycle: the result store on a done pulse, and a software read of that same result register. The bench provokes this by presenting the result address and the done pulse on the same edge. It then checks that the read data shows the old sample first and the new sample one cycle later. A second overlap is the restart and interrupt caused by one done pulse. The bench checks both in the same cycle, and checks that a control write landing while a conversion is in flight changes only the following start.

// File: rtl/adc_gate_pkg.sv
package adc_gate_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1} seq_state_t;
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_CMP   = 1;
  localparam int CTRL_BELOW = 2;
  localparam int CTRL_CHAN  = 4;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_THR   = 1;
endpackage

// File: rtl/adc_gate_regs.sv
module adc_gate_regs
  import adc_gate_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int THR_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              run_en,
  output logic              cmp_en,
  output logic              cmp_below,
  output logic [CH_W-1:0]   sel_chan,
  output logic [THR_W-1:0]  thr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      cmp_en    <= 1'b0;
      cmp_below <= 1'b0;
      sel_chan  <= '0;
      thr       <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADDR_CTRL)) begin
        run_en    <= wdata[CTRL_RUN];
        cmp_en    <= wdata[CTRL_CMP];
        cmp_below <= wdata[CTRL_BELOW];
        sel_chan  <= wdata[CTRL_CHAN +: CH_W];
      end else if (addr == ADDR_W'(ADDR_THR)) begin
        thr <= wdata[THR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_gate_seq.sv
module adc_gate_seq
  import adc_gate_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_en,
  input  logic [CH_W-1:0] sel_chan,
  input  logic            conv_done,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan,
  output logic            accept
);
  seq_state_t state;

  assign accept = conv_done && (state == SEQ_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (run_en) begin
            conv_start <= 1'b1;
            conv_chan  <= sel_chan;
            state      <= SEQ_BUSY;
          end
        end
        default: begin
          if (conv_done) begin
            if (run_en) begin
              conv_start <= 1'b1;
              conv_chan  <= sel_chan;
            end else begin
              state <= SEQ_IDLE;
            end
          end
        end
      endcase
    end
  end

  AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> $past(run_en)); // R2
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (accept && run_en) |=> conv_start); // R4
  AST_HALT: assert property (@(posedge clk) disable iff (rst)
    (accept && !run_en) |=> !conv_start); // R8
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_BUSY && !conv_done) |=> $stable(conv_chan)); // R4
  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && !run_en) |=> !conv_start); // R9
endmodule

// File: rtl/adc_gate_store.sv
module adc_gate_store
  import adc_gate_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int THR_W  = 8,
  parameter int DATA_W = 16,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [RES_W-1:0]  conv_result,
  input  logic              run_en,
  input  logic              cmp_en,
  input  logic              cmp_below,
  input  logic [CH_W-1:0]   sel_chan,
  input  logic [THR_W-1:0]  thr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              irq,
  output logic [DATA_W-1:0] rdata
);
  logic [RES_W-1:0]  res_mem [NUM_CH];
  logic [THR_W-1:0]  upper;
  logic              hit;
  logic              fire;
  logic [DATA_W-1:0] ctrl_word;

  assign upper = conv_result[RES_W-1 -: THR_W];
  assign hit   = cmp_below ? (upper < thr) : (upper >= thr);
  assign fire  = accept && (!cmp_en || hit);

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_RUN]           = run_en;
    ctrl_word[CTRL_CMP]           = cmp_en;
    ctrl_word[CTRL_BELOW]         = cmp_below;
    ctrl_word[CTRL_CHAN +: CH_W]  = sel_chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CH; i++) res_mem[i] <= '0;
    end else if (accept) begin
      res_mem[wr_chan] <= conv_result;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      irq <= fire;
      if (rd_addr[ADDR_W-1])
        rdata <= DATA_W'(res_mem[rd_addr[CH_W-1:0]]);
      else if (rd_addr == ADDR_W'(ADDR_CTRL))
        rdata <= ctrl_word;
      else if (rd_addr == ADDR_W'(ADDR_THR))
        rdata <= DATA_W'(thr);
      else
        rdata <= '0;
    end
  end

  AST_STORE: assert property (@(posedge clk) disable iff (rst)
    accept |=> (res_mem[$past(wr_chan)] == $past(conv_result))); // R3
  AST_IRQ_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (accept && !cmp_en) |=> irq); // R5
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !irq); // R9
  AST_IRQ_ABOVE: assert property (@(posedge clk) disable iff (rst)
    (accept && cmp_en && !cmp_below) |=> (irq == ($past(upper) >= $past(thr)))); // R6
  AST_IRQ_BELOW: assert property (@(posedge clk) disable iff (rst)
    (accept && cmp_en && cmp_below) |=> (irq == ($past(upper) < $past(thr)))); // R7
endmodule

// File: rtl/adc_gate_seq_top.sv
module adc_gate_seq_top
  import adc_gate_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int THR_W  = 8,
  parameter int DATA_W = 16,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  output logic              irq
);
  logic             run_en, cmp_en, cmp_below, accept;
  logic [CH_W-1:0]  sel_chan;
  logic [THR_W-1:0] thr;

  adc_gate_regs #(.CH_W(CH_W), .THR_W(THR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .run_en(run_en), .cmp_en(cmp_en), .cmp_below(cmp_below),
    .sel_chan(sel_chan), .thr(thr)
  );

  adc_gate_seq #(.CH_W(CH_W)) u_seq (
    .clk(clk), .rst(rst), .run_en(run_en), .sel_chan(sel_chan),
    .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
    .accept(accept)
  );

  adc_gate_store #(.NUM_CH(NUM_CH), .RES_W(RES_W), .THR_W(THR_W), .DATA_W(DATA_W),
                   .CH_W(CH_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .accept(accept), .wr_chan(conv_chan),
    .conv_result(conv_result), .run_en(run_en), .cmp_en(cmp_en),
    .cmp_below(cmp_below), .sel_chan(sel_chan), .thr(thr),
    .rd_addr(reg_addr), .irq(irq), .rdata(reg_rdata)
  );
endmodule

// File: tb/sim_adc_gate_seq_top.sv
`timescale 1ns/1ps
module sim_adc_gate_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = '0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit m_cmp = 0, m_below = 0;
  logic [7:0] m_thr = '0;

  always #4 clk = ~clk;

  adc_gate_seq_top u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
    .conv_result(conv_result), .conv_start(conv_start), .conv_chan(conv_chan),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic want_irq(input logic [9:0] res);
    if (!m_cmp) return 1'b1;
    if (m_below) return res[9:2] < m_thr;
    return res[9:2] >= m_thr;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ctrl(input bit run, input bit cmp, input bit below, input logic [2:0] ch);
    m_cmp = cmp; m_below = below;
    wr(4'd0, {9'd0, ch, 1'b0, below, cmp, run});
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic conv(input logic [9:0] res, input bit exp_start, input string tag);
    logic e;
    e = want_irq(res);
    conv_done = 1'b1; conv_result = res;
    @(negedge clk);
    conv_done = 1'b0;
    chk(tag, irq, e);
    chk("R4 restart", conv_start, exp_start);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 start", conv_start, 0);
    chk("R1 irq", irq, 0);
    rd(4'd0, v); chk("R1 ctrl", v, 0);
    rd(4'd1, v); chk("R1 thr", v, 0);
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), v); chk("R1 result", v, 0);
    end
  endtask

  task automatic t_start();
    set_ctrl(1, 0, 0, 3'd5);
    chk("R2 early", conv_start, 0);
    @(negedge clk);
    chk("R2 start", conv_start, 1);
    chk("R2 chan", conv_chan, 5);
    @(negedge clk);
    chk("R2 one cycle", conv_start, 0);
  endtask

  task automatic t_plain();
    logic [15:0] v;
    conv(10'h155, 1, "R5 irq");
    chk("R4 same chan", conv_chan, 5);
    @(negedge clk);
    chk("R5 one cycle", irq, 0);
    rd(4'd13, v); chk("R3 stored", v, 16'h155);
    conv(10'h000, 1, "R5 irq zero");
  endtask

  task automatic t_above();
    m_thr = 8'h80; wr(4'd1, 16'h0080);
    set_ctrl(1, 1, 0, 3'd5);
    conv(10'h200, 1, "R6 equal");
    conv(10'h1FF, 1, "R6 under");
    conv(10'h3FF, 1, "R6 max");
  endtask

  task automatic t_below();
    set_ctrl(1, 1, 1, 3'd5);
    conv(10'h1FF, 1, "R7 under");
    conv(10'h200, 1, "R7 equal");
    conv(10'h000, 1, "R7 zero");
    m_thr = 8'h10; wr(4'd1, 16'h0010);
    conv(10'h1FF, 1, "R10 new thr");
    set_ctrl(1, 0, 0, 3'd5);
    conv(10'h1FF, 1, "R10 cmp off");
  endtask

  task automatic t_switch();
    logic [15:0] v;
    set_ctrl(1, 0, 0, 3'd2);
    chk("R4 chan held", conv_chan, 5);
    conv(10'h0AA, 1, "R5 irq");
    chk("R4 new chan", conv_chan, 2);
    conv(10'h0BB, 1, "R5 irq");
    rd(4'd13, v); chk("R3 ch5", v, 16'h0AA);
    rd(4'd10, v); chk("R3 ch2", v, 16'h0BB);
  endtask

  task automatic t_collide();
    reg_addr = 4'd10;
    conv_done = 1'b1; conv_result = 10'h123;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R11 old value", reg_rdata, 16'h0BB);
    chk("R5 irq", irq, 1);
    @(negedge clk);
    chk("R11 new value", reg_rdata, 16'h123);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    set_ctrl(0, 0, 0, 3'd2);
    conv(10'h321, 0, "R8 irq");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R8 no start", conv_start, 0);
    end
    rd(4'd10, v); chk("R8 stored", v, 16'h321);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    conv_done = 1'b1; conv_result = 10'h3FF;
    @(negedge clk);
    conv_done = 1'b0;
    chk("R9 irq", irq, 0);
    chk("R9 start", conv_start, 0);
    rd(4'd10, v); chk("R9 unchanged", v, 16'h321);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start();
    t_plain();
    t_above();
    t_below();
    t_switch();
    t_collide();
    t_stop();
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule